// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block is the master side of a 32-bit bus whose address and data share one set of lines. It runs one transaction at a time. A request carries a byte address, a direction, a port width code, a SIZE code (the beat count minus one) and up to four words of write data. The request port is valid/ready. `req_ready` is high only while the block is idle. A requester may hold `req_valid` and its fields steady for as long as it likes, and the request is taken on the first rising edge where both signals are high. Read beats come back on a plain strobe (`rd_valid`, `rd_data`, `rd_beat`) with no back-pressure: the consumer must take each beat in the cycle it is shown.

An accepted request gives one address cycle. In that cycle the shared lines carry the word address in bits 31:2 and the SIZE code in bits 1:0. Latch enable is high and the address strobe is low. Data cycles follow, one per beat. A beat ends on each rising edge at which the active-low ready input is low. The low partial-address outputs advance by the port width after each beat. When the bus is idle it keeps a defined value that depends on the last transaction. A request that is malformed, or whose burst would leave its aligned 16-byte block, is refused with a one-cycle error pulse.

Top module: `muxbus_master`

## Requirements
- R1: In the cycle after a request is accepted, `ad_oe`=1 and `ad_out` carries `req_addr[31:2]` in bits 31:2 and the SIZE code in bits 1:0. The SIZE code means 00=1, 01=2, 10=3 and 11=4 beats.
- R2: `ale`=1 and `ads_n`=0 during the address cycle and only then. `ale_n` is always the inverse of `ale`.
- R3: Width codes are 0=8-bit, 1=16-bit and 2=32-bit. `a_hi` shows partial address bits 3:2. `be_lo` is 00 for 32-bit, {A1,0} for 16-bit and {A1,A0} for 8-bit. The start value comes from `req_addr[3:0]`, with the low bits cleared to the width's alignment.
- R4: The partial address steps by 1, 2 or 4 bytes (8, 16 or 32-bit) on each edge where `rdy_n`=0 ends a beat that is not the last. It holds while `rdy_n`=1.
- R5: In a write data cycle, `ad_oe`=1. Write word k (`req_wdata[32k+31:32k]`) goes out on the active lanes: all four lanes for 32-bit, the halfword lanes chosen by A1 from its low 16 bits for 16-bit, and byte lane A[1:0] from its low byte for 8-bit. All other lanes are 0.
- R6: In a read data cycle, `ad_oe`=0. The active lanes of `ad_in` are captured, zero-extended and right-aligned on the edge where `rdy_n`=0. They appear in the next cycle with a one-cycle `rd_valid` and `rd_beat` set to the beat index.
- R7: A transaction ends on the edge that completes beat SIZE. `req_ready` is high in the next cycle, and a request held at that time is accepted on the following edge.
- R8: While idle after a write, `ad_out` = {last driven data[31:2], SIZE}. While idle after a read, `ad_out` = {address[31:4], partial address bits 3:2 of the last beat, SIZE}.
- R9: A request with width code 3, or whose aligned start plus (SIZE+1)×width bytes exceeds 16, is accepted and refused. `req_err` pulses high for the next cycle and no address cycle starts.
- R10: After reset, `req_ready`=1, `ale`=0, `ads_n`=1, `rd_valid`=0 and `ad_out`=0. `req_ready` is 0 from the address cycle until the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Byte start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Port width code |
| req_size | input | 2 | SIZE code, beats minus one |
| req_wdata | input | 128 | Write words, beat k in bits 32k+31:32k |
| req_err | output | 1 | One-cycle refusal pulse |
| ad_out | output | 32 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 32 | Shared lines, incoming value |
| ale | output | 1 | Address latch enable, active high |
| ale_n | output | 1 | Inverse of ale |
| ads_n | output | 1 | Address strobe, active low |
| a_hi | output | 2 | Partial address bits 3:2 |
| be_lo | output | 2 | Low partial address bits for narrow ports |
| rdy_n | input | 1 | Beat ready, active low |
| rd_valid | output | 1 | Read beat strobe |
| rd_data | output | 32 | Read beat data, right-aligned |
| rd_beat | output | 2 | Index of the returned beat |

## Verification
Two functions can land in the same cycle: the return of the final read beat and the reopening of the request port. To provoke this, a new request is held on `req_valid` while the last `rdy_n` of a read burst is given. The check requires that the request is not taken on that edge. In the following cycle `rd_valid` must show the last beat while `req_ready` is high, and the new address cycle must start one edge later.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int PART_W  = 4;
  localparam int BLOCK_B = 1 << PART_W;

  typedef enum logic [1:0] {
    PW_8   = 2'd0,
    PW_16  = 2'd1,
    PW_32  = 2'd2,
    PW_BAD = 2'd3
  } port_w_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/muxbus_req_check.sv
module muxbus_req_check
  import muxbus_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  port_w_e             width,
  input  logic [PART_W-1:0]   start,
  input  logic [CNT_W-1:0]    size,
  output logic                ok
);
  localparam int SPAN_W = PART_W + 3;

  logic [PART_W-1:0] aligned;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] stop;

  always_comb begin
    case (width)
      PW_16:   aligned = {start[PART_W-1:1], 1'b0};
      PW_32:   aligned = {start[PART_W-1:2], 2'b00};
      default: aligned = start;
    endcase
    span = (SPAN_W'(size) + SPAN_W'(1)) << width;
    stop = SPAN_W'(aligned) + span;
    ok   = (width != PW_BAD) && (stop <= SPAN_W'(BLOCK_B));
  end
endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes
  import muxbus_pkg::*;
(
  input  port_w_e             width,
  input  logic [1:0]          sel,
  input  logic [BUS_W-1:0]    wword,
  input  logic [BUS_W-1:0]    rbus,
  output logic [BUS_W-1:0]    wbus,
  output logic [BUS_W-1:0]    rword
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       w_en;
    logic [7:0] w_src;
    logic [1:0] r_idx;
    logic       r_en;

    always_comb begin
      case (width)
        PW_32: begin
          w_en  = 1'b1;
          w_src = wword[8*i +: 8];
          r_en  = 1'b1;
          r_idx = 2'(i);
        end
        PW_16: begin
          w_en  = ((i / 2) == int'(sel[1]));
          w_src = wword[8*(i % 2) +: 8];
          r_en  = (i < 2);
          r_idx = {sel[1], 1'(i % 2)};
        end
        PW_8: begin
          w_en  = (i == int'(sel));
          w_src = wword[7:0];
          r_en  = (i == 0);
          r_idx = sel;
        end
        default: begin
          w_en  = 1'b0;
          w_src = 8'h00;
          r_en  = 1'b0;
          r_idx = 2'd0;
        end
      endcase
    end

    assign wbus[8*i +: 8]  = w_en ? w_src : 8'h00;
    assign rword[8*i +: 8] = r_en ? rbus[8*r_idx +: 8] : 8'h00;
  end
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PART_W-1:0]   start_part,
  input  port_w_e             width,
  input  logic [CNT_W-1:0]    size,
  input  logic                rdy_n,
  output phase_e              phase,
  output logic [CNT_W-1:0]    beat,
  output logic [CNT_W-1:0]    size_q,
  output logic [PART_W-1:0]   part,
  output logic                last_done
);
  logic [PART_W-1:0] step_q;
  logic [PART_W-1:0] aligned;

  always_comb begin
    case (width)
      PW_16:   aligned = {start_part[PART_W-1:1], 1'b0};
      PW_32:   aligned = {start_part[PART_W-1:2], 2'b00};
      default: aligned = start_part;
    endcase
  end

  assign last_done = (phase == PH_DATA) && !rdy_n && (beat == size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      beat   <= '0;
      size_q <= '0;
      part   <= '0;
      step_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_ADDR;
          beat   <= '0;
          size_q <= size;
          part   <= aligned;
          step_q <= PART_W'(1) << width;
        end
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: if (!rdy_n) begin
          if (beat == size_q) begin
            phase <= PH_IDLE;
          end else begin
            beat <= beat + 1'b1;
            part <= part + step_q;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r4_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && rdy_n) |=> $stable(part));

  a_r4_step_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !rdy_n && beat != size_q) |=> (part == $past(part) + step_q));

  a_r7_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (beat <= size_q));
endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BUS_W-1:0]          req_addr,
  input  logic                      req_write,
  input  logic [1:0]                req_width,
  input  logic [1:0]                req_size,
  input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
  output logic                      req_err,
  output logic [BUS_W-1:0]          ad_out,
  output logic                      ad_oe,
  input  logic [BUS_W-1:0]          ad_in,
  output logic                      ale,
  output logic                      ale_n,
  output logic                      ads_n,
  output logic [1:0]                a_hi,
  output logic [1:0]                be_lo,
  input  logic                      rdy_n,
  output logic                      rd_valid,
  output logic [BUS_W-1:0]          rd_data,
  output logic [1:0]                rd_beat
);
  localparam int CNT_W = $clog2(MAX_BEATS);

  phase_e                    phase;
  logic [CNT_W-1:0]          beat;
  logic [CNT_W-1:0]          size_q;
  logic [PART_W-1:0]         part;
  logic                      last_done;
  logic                      req_ok;
  logic                      accept;
  logic                      start;
  port_w_e                   req_w_e;
  port_w_e                   width_q;
  logic [BUS_W-1:0]          addr_q;
  logic                      write_q;
  logic [MAX_BEATS*BUS_W-1:0] wdata_q;
  logic [BUS_W-1:0]          wword;
  logic [BUS_W-1:0]          wbus;
  logic [BUS_W-1:0]          rword;
  logic [BUS_W-3:0]          hold_hi;
  logic [1:0]                hold_size;
  logic                      beat_done;

  assign req_w_e   = port_w_e'(req_width);
  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && req_ok;
  assign beat_done = (phase == PH_DATA) && !rdy_n;
  assign wword     = wdata_q[beat*BUS_W +: BUS_W];

  muxbus_req_check #(.CNT_W(CNT_W)) u_check (
    .width (req_w_e),
    .start (req_addr[PART_W-1:0]),
    .size  (CNT_W'(req_size)),
    .ok    (req_ok)
  );

  muxbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_part (req_addr[PART_W-1:0]),
    .width      (req_w_e),
    .size       (CNT_W'(req_size)),
    .rdy_n      (rdy_n),
    .phase      (phase),
    .beat       (beat),
    .size_q     (size_q),
    .part       (part),
    .last_done  (last_done)
  );

  muxbus_lanes u_lanes (
    .width (width_q),
    .sel   (part[1:0]),
    .wword (wword),
    .rbus  (ad_in),
    .wbus  (wbus),
    .rword (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      write_q   <= 1'b0;
      width_q   <= PW_32;
      wdata_q   <= '0;
      req_err   <= 1'b0;
      hold_hi   <= '0;
      hold_size <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_beat   <= '0;
    end else begin
      req_err  <= accept && !req_ok;
      rd_valid <= beat_done && !write_q;
      if (start) begin
        addr_q  <= req_addr;
        write_q <= req_write;
        width_q <= req_w_e;
        wdata_q <= req_wdata;
      end
      if (beat_done && !write_q) begin
        rd_data <= rword;
        rd_beat <= 2'(beat);
      end
      if (last_done) begin
        hold_hi   <= write_q ? wbus[BUS_W-1:2]
                             : {addr_q[BUS_W-1:PART_W], part[PART_W-1:2]};
        hold_size <= 2'(size_q);
      end
    end
  end

  always_comb begin
    case (phase)
      PH_ADDR: ad_out = {addr_q[BUS_W-1:2], 2'(size_q)};
      PH_DATA: ad_out = write_q ? wbus
                                : {addr_q[BUS_W-1:PART_W], part[PART_W-1:2], 2'(size_q)};
      default: ad_out = {hold_hi, hold_size};
    endcase
    case (width_q)
      PW_8:    be_lo = part[1:0];
      PW_16:   be_lo = {part[1], 1'b0};
      default: be_lo = 2'b00;
    endcase
  end

  assign ad_oe = !((phase == PH_DATA) && !write_q);
  assign ale   = (phase == PH_ADDR);
  assign ale_n = !ale;
  assign ads_n = (phase != PH_ADDR);
  assign a_hi  = part[PART_W-1:2];

  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r2_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!ads_n && !ale_n));

  a_r9_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!ale && ads_n && req_ready));

  a_r7_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat == 2'(size_q)) |-> req_ready);

  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!ad_oe)));
endmodule

// File: tb/muxbus_master_tb_top.sv
module muxbus_master_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_write = 1'b0;
  logic [1:0]   req_width = 2'd2;
  logic [1:0]   req_size = 2'd0;
  logic [127:0] req_wdata = '0;
  logic         req_err;
  logic [31:0]  ad_out;
  logic         ad_oe;
  logic [31:0]  ad_in = '0;
  logic         ale, ale_n, ads_n;
  logic [1:0]   a_hi, be_lo;
  logic         rdy_n = 1'b1;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [1:0]   rd_beat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  muxbus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_width(req_width),
    .req_size(req_size), .req_wdata(req_wdata), .req_err(req_err),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .ale_n(ale_n),
    .ads_n(ads_n), .a_hi(a_hi), .be_lo(be_lo), .rdy_n(rdy_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] w,
                      input logic [1:0] s, input logic [127:0] wd);
    req_addr = a; req_write = wr; req_width = w; req_size = s; req_wdata = wd;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset req_ready", 32'(req_ready), 32'd1);
    chk("R10 reset ale", 32'(ale), 32'd0);
    chk("R10 reset ads_n", 32'(ads_n), 32'd1);
    chk("R2 reset ale_n", 32'(ale_n), 32'd1);
    chk("R10 reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R10 reset ad_out", ad_out, 32'd0);
  endtask

  task automatic t_write32_burst;
    logic [31:0] d [4];
    d[0] = 32'hA1B2C3D4; d[1] = 32'h0F1E2D3C; d[2] = 32'h55AA55AA; d[3] = 32'hDEADBEE4;
    send(32'h1000_0000, 1'b1, 2'd2, 2'd3, {d[3], d[2], d[1], d[0]});
    chk("R1 addr phase ad_out", ad_out, 32'h1000_0003);
    chk("R1 addr phase ad_oe", 32'(ad_oe), 32'd1);
    chk("R2 addr phase ale", 32'(ale), 32'd1);
    chk("R2 addr phase ale_n", 32'(ale_n), 32'd0);
    chk("R2 addr phase ads_n", 32'(ads_n), 32'd0);
    chk("R10 busy req_ready", 32'(req_ready), 32'd0);
    step();
    for (int b = 0; b < 4; b++) begin
      chk("R2 data ale", 32'(ale), 32'd0);
      chk("R2 data ads_n", 32'(ads_n), 32'd1);
      chk("R5 write32 lanes", ad_out, d[b]);
      chk("R3 write32 a_hi", 32'(a_hi), 32'(b));
      chk("R3 write32 be_lo", 32'(be_lo), 32'd0);
      if (b == 1) begin
        step();
        chk("R4 wait holds a_hi", 32'(a_hi), 32'd1);
        chk("R5 wait holds data", ad_out, d[1]);
      end
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1;
    end
    chk("R7 write done req_ready", 32'(req_ready), 32'd1);
    chk("R8 idle after write", ad_out, {d[3][31:2], 2'b11});
    chk("R5 idle drives", 32'(ad_oe), 32'd1);
  endtask

  task automatic t_write8_lanes;
    send(32'h3000_0009, 1'b1, 2'd0, 2'd2, {32'h0, 32'hFFFFFF33, 32'hFFFFFF22, 32'hFFFFFF11});
    chk("R1 write8 addr phase", ad_out, 32'h3000_000A);
    chk("R3 write8 start be_lo", 32'(be_lo), 32'd1);
    chk("R3 write8 start a_hi", 32'(a_hi), 32'd2);
    step();
    for (int b = 0; b < 3; b++) begin
      chk("R4 write8 be_lo step", 32'(be_lo), 32'(b + 1));
      chk("R5 write8 single lane", ad_out, 32'(8'h11 + 8'(b * 17)) << (8 * (b + 1)));
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1;
    end
    chk("R8 idle after write8", ad_out, 32'h3300_0002);
  endtask

  task automatic t_read16;
    send(32'h2000_0004, 1'b0, 2'd1, 2'd1, '0);
    chk("R1 read16 addr phase", ad_out, 32'h2000_0005);
    step();
    chk("R6 read releases bus", 32'(ad_oe), 32'd0);
    chk("R3 read16 a_hi", 32'(a_hi), 32'd1);
    chk("R3 read16 be_lo beat0", 32'(be_lo), 32'd0);
    ad_in = 32'hAAAA_1234;
    rdy_n = 1'b0;
    step();
    rdy_n = 1'b1;
    chk("R6 read16 beat0 valid", 32'(rd_valid), 32'd1);
    chk("R6 read16 beat0 index", 32'(rd_beat), 32'd0);
    chk("R6 read16 beat0 data", rd_data, 32'h0000_1234);
    chk("R4 read16 be_lo beat1", 32'(be_lo), 32'd2);
    step();
    chk("R6 valid is one cycle", 32'(rd_valid), 32'd0);
    ad_in = 32'h5678_BBBB;
    rdy_n = 1'b0;
    step();
    rdy_n = 1'b1;
    chk("R6 read16 beat1 data", rd_data, 32'h0000_5678);
    chk("R6 read16 beat1 index", 32'(rd_beat), 32'd1);
    chk("R7 read done req_ready", 32'(req_ready), 32'd1);
    chk("R8 idle after read", ad_out, 32'h2000_0005);
    step();
    chk("R6 no extra valid", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_reject;
    send(32'h6000_0008, 1'b1, 2'd2, 2'd2, '0);
    chk("R9 cross reject err", 32'(req_err), 32'd1);
    chk("R9 cross reject no ale", 32'(ale), 32'd0);
    chk("R9 cross reject ready", 32'(req_ready), 32'd1);
    step();
    chk("R9 err is a pulse", 32'(req_err), 32'd0);
    chk("R9 still no strobe", 32'(ads_n), 32'd1);
    send(32'h6000_0000, 1'b0, 2'd3, 2'd0, '0);
    chk("R9 bad width err", 32'(req_err), 32'd1);
    chk("R9 bad width no ale", 32'(ale), 32'd0);
    step();
    send(32'h6000_000C, 1'b0, 2'd0, 2'd3, '0);
    chk("R9 exact fit accepted", 32'(ale), 32'd1);
    chk("R9 exact fit no err", 32'(req_err), 32'd0);
    step();
    for (int b = 0; b < 4; b++) begin
      chk("R4 read8 be_lo step", 32'(be_lo), 32'(b));
      chk("R3 read8 a_hi", 32'(a_hi), 32'd3);
      ad_in = 32'h4433_2211 + 32'(b);
      rdy_n = 1'b0;
      step();
      rdy_n = 1'b1;
      chk("R6 read8 lane pick", rd_data, 32'((32'h4433_2211 + 32'(b)) >> (8 * b)) & 32'hFF);
    end
    chk("R7 read8 done", 32'(req_ready), 32'd1);
  endtask

  task automatic t_overlap;
    send(32'h4000_0008, 1'b0, 2'd2, 2'd0, '0);
    step();
    ad_in = 32'hCAFE_F00D;
    rdy_n = 1'b0;
    req_addr = 32'h5000_0000; req_write = 1'b1; req_width = 2'd2;
    req_size = 2'd0; req_wdata = {96'h0, 32'h1234_5678};
    req_valid = 1'b1;
    step();
    rdy_n = 1'b1;
    chk("R7 held request not taken in data", 32'(ale), 32'd0);
    chk("R7 ready with last beat", 32'(req_ready), 32'd1);
    chk("R6 last read beat valid", 32'(rd_valid), 32'd1);
    chk("R6 last read beat data", rd_data, 32'hCAFE_F00D);
    step();
    req_valid = 1'b0;
    chk("R7 next address cycle", 32'(ale), 32'd1);
    chk("R1 next address value", ad_out, 32'h5000_0000);
    step();
    chk("R5 next write data", ad_out, 32'h1234_5678);
    rdy_n = 1'b0;
    step();
    rdy_n = 1'b1;
    chk("R7 next write done", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write32_burst();
    t_read16();
    t_write8_lanes();
    t_reject();
    t_overlap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule